// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is a receive-only serial port. The shift clock comes from an external master, and the block never drives it. Both the shift clock and the data line are brought into the system clock domain through a two-flop synchronizer. An edge detector finds the falling clock edges. On each falling edge one data bit is captured, least significant bit first, into a shift register. A word is 8 bits long, or 9 bits when the ninth-bit control is set. Each finished word goes into a two-entry holding buffer.

The buffer's output is a valid/ready stream. `rx_valid` is high while at least one word is held, and it also serves as the receive-complete flag. A word is consumed in any cycle where `rx_valid` and `rx_ready` are both high. The consumer may hold `rx_ready` low for any length of time. During that wait the head word and its ninth bit stay stable, and up to two words are kept. If a third word completes while both entries are full, that word is lost and an overrun is latched.

Status is read from an 8-bit status output. An interrupt request and a wake request are derived from the buffer state. The low-power input does not stop reception.

Top module: `sync_slave_rx`

## Requirements
- R1: A word is accepted only while `port_en`=1, `sync_mode`=1, `clk_src_master`=0 and `cont_rx_en`=1. If any of these conditions fails, falling shift-clock edges are ignored and no word appears on `rx_valid`.
- R2: `single_rx_en` has no effect on reception.
- R3: Bits are captured on falling edges of `sclk_in`, least significant bit first. In 8-bit mode the 8th falling edge completes a word. `rx_valid` rises on the 3rd rising system-clock edge after that falling edge, with `rx_data` holding the word.
- R4: When `nine_bit_en`=1, a word takes 9 falling edges. The 9th received bit appears at `rx_status[0]` for as long as that word is at the head of the buffer, and `rx_data` holds the low 8 bits. `rx_status[0]` is 0 when the head word arrived in 8-bit mode or when the buffer is empty.
- R5: The holding buffer keeps two words in arrival order. A word is removed when `rx_valid` and `rx_ready` are both high. `rx_valid` falls once the buffer is empty. While `rx_ready` is low, `rx_valid` and `rx_data` hold.
- R6: `rx_irq` is high exactly when `rx_valid`=1 and `rx_int_en`=1.
- R7: If a word completes while the buffer is full and nothing is being popped, the following happens:
  - `rx_status[1]` (overrun) is set.
  - The new word is discarded and the stored words are kept.
  - No further word is accepted while the overrun is set.
- R8: The overrun flag stays set until `cont_rx_en` is driven low. Clearing `port_en` does not clear it.
- R9: Driving `cont_rx_en` or `port_en` low abandons a partly received word. The next word then starts from bit 0.
- R10: `low_power` does not stop reception. `wake_req` is high when `low_power`=1 and `rx_irq`=1.
- R11: `rx_status` bits 7 down to 0 read `port_en`, `nine_bit_en`, `single_rx_en`, `cont_rx_en`, 0, 0, overrun, ninth bit. After reset with all inputs low, it reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | Clock source select; 0 = external clock (slave) |
| nine_bit_en | input | 1 | 9-bit word select |
| single_rx_en | input | 1 | Single-receive enable; ignored in slave mode |
| cont_rx_en | input | 1 | Continuous-receive enable; low clears overrun |
| rx_int_en | input | 1 | Receive interrupt enable |
| low_power | input | 1 | Low-power indication |
| sclk_in | input | 1 | External shift clock, idle high |
| sdata_in | input | 1 | Serial data line |
| rx_valid | output | 1 | Head word valid / receive complete |
| rx_ready | input | 1 | Consumer takes the head word |
| rx_data | output | 8 | Low 8 bits of the head word |
| rx_status | output | 8 | Receive status register |
| rx_irq | output | 1 | Receive interrupt request |
| wake_req | output | 1 | Wake request while in low power |

## Verification
A falling edge on `sclk_in` passes through two synchronizer flops before the edge detector sees it. The bit is then written into the buffer on the third rising system edge. The latency test samples `rx_valid` after the second of those edges, expecting 0, and again after the third, expecting 1.

Inputs change and outputs are sampled only on falling system-clock edges. Each shift-clock half period lasts six system cycles, so every word is in the buffer before the data task returns. `rx_irq`, `wake_req` and `rx_status` are combinational from buffer and overrun state, so each check on them waits one cycle after a pop or a control change.

// File: rtl/sslv_pkg.sv
package sslv_pkg;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned BUF_DEP = 2;
  parameter int unsigned SYNC_N  = 2;
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sslv_edge_sync.sv
module sslv_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic fall,
  output logic dout
);
  logic [STAGES:0]   ck_pipe;
  logic [STAGES-1:0] d_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_pipe <= '1;
      d_pipe  <= '0;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-1:0], sclk_in};
      d_pipe  <= {d_pipe[STAGES-2:0], sdata_in};
    end
  end

  assign fall = ck_pipe[STAGES] & ~ck_pipe[STAGES-1];
  assign dout = d_pipe[STAGES-1];
endmodule

// File: rtl/sslv_shifter.sv
module sslv_shifter
  import sslv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  enable,
  input  logic  nine,
  input  logic  fall,
  input  logic  din,
  output logic  done,
  output word_t word
);
  logic [CNT_W-1:0] cnt, last;
  word_t sr, sr_next;
  logic  take;

  assign last = nine ? CNT_W'(WORD_W - 1) : CNT_W'(DATA_W - 1);
  assign take = fall & enable;
  assign done = take & (cnt >= last);

  always_comb begin
    sr_next = sr;
    for (int i = 0; i < WORD_W; i++)
      if (cnt == CNT_W'(i)) sr_next[i] = din;
  end

  assign word = nine ? sr_next : {1'b0, sr_next[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (clear) begin
      cnt <= '0;
      sr  <= '0;
    end else if (take) begin
      if (done) begin
        cnt <= '0;
        sr  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        sr  <= sr_next;
      end
    end
  end
endmodule

// File: rtl/sslv_fifo.sv
module sslv_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             empty,
  output logic             drop,
  output logic [WIDTH-1:0] head
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign drop    = push & full & ~do_pop;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sslv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic        sync_mode,
  input  logic        clk_src_master,
  input  logic        nine_bit_en,
  input  logic        single_rx_en,
  input  logic        cont_rx_en,
  input  logic        rx_int_en,
  input  logic        low_power,
  input  logic        sclk_in,
  input  logic        sdata_in,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [7:0]  rx_data,
  output logic [7:0]  rx_status,
  output logic        rx_irq,
  output logic        wake_req
);
  logic  fall, din, done, drop, empty, ovf, active, ninth;
  word_t word, head;

  assign active = port_en & sync_mode & ~clk_src_master & cont_rx_en;

  sslv_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .fall(fall), .dout(din)
  );

  sslv_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(~active), .enable(active & ~ovf),
    .nine(nine_bit_en), .fall(fall), .din(din), .done(done), .word(word)
  );

  sslv_fifo #(.DEPTH(BUF_DEP), .WIDTH(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(done), .push_data(word),
    .pop(rx_valid & rx_ready), .empty(empty), .drop(drop), .head(head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovf <= 1'b0;
    else if (!cont_rx_en) ovf <= 1'b0;
    else if (drop)        ovf <= 1'b1;
  end

  assign rx_valid  = ~empty;
  assign rx_data   = head[7:0];
  assign ninth     = ~empty & head[DATA_W];
  assign rx_status = {port_en, nine_bit_en, single_rx_en, cont_rx_en,
                      1'b0, 1'b0, ovf, ninth};
  assign rx_irq    = rx_valid & rx_int_en;
  assign wake_req  = rx_irq & low_power;
endmodule

// File: rtl/sslv_checker.sv
module sslv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       sync_mode,
  input logic       clk_src_master,
  input logic       cont_rx_en,
  input logic       low_power,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic [7:0] rx_status,
  input logic       wake_req
);
  // R1
  idle_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(port_en && sync_mode && !clk_src_master && cont_rx_en) && !rx_valid) |=> !rx_valid);

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status[1] && cont_rx_en) |=> rx_status[1]);

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_rx_en |=> !rx_status[1]);

  // R10
  wake_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (rx_valid && low_power));
endmodule

bind sync_slave_rx sslv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
  .clk_src_master(clk_src_master), .cont_rx_en(cont_rx_en),
  .low_power(low_power), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_status(rx_status), .wake_req(wake_req)
);

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic port_en = 0, sync_mode = 0, clk_src_master = 0, nine_bit_en = 0;
  logic single_rx_en = 0, cont_rx_en = 0, rx_int_en = 0, low_power = 0;
  logic sclk_in = 1, sdata_in = 0, rx_ready = 0;
  logic rx_valid, rx_irq, wake_req;
  logic [7:0] rx_data, rx_status;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sync_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_src_master(clk_src_master), .nine_bit_en(nine_bit_en),
    .single_rx_en(single_rx_en), .cont_rx_en(cont_rx_en),
    .rx_int_en(rx_int_en), .low_power(low_power), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_status(rx_status), .rx_irq(rx_irq),
    .wake_req(wake_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slave_on();
    @(negedge clk);
    port_en = 1; sync_mode = 1; clk_src_master = 0; cont_rx_en = 1;
  endtask

  task automatic send(input logic [8:0] v, input int n, input bit lat);
    for (int i = 0; i < n; i++) begin
      sdata_in = v[i];
      repeat (HALF) @(negedge clk);
      sclk_in = 0;
      if (lat && i == n - 1) begin
        repeat (2) @(negedge clk);
        chk("R3 latency before", rx_valid, 0);
        @(negedge clk);
        chk("R3 latency due", rx_valid, 1);
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk_in = 1;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pop();
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset status", rx_status, 8'h00);
    chk("R5 reset valid", rx_valid, 0);
    chk("R6 reset irq", rx_irq, 0);
  endtask

  task automatic t_basic8();
    slave_on();
    send(9'h0A5, 8, 1);
    chk("R3 data", rx_data, 8'hA5);
    chk("R4 ninth in 8-bit", rx_status[0], 0);
    chk("R6 irq off", rx_irq, 0);
    pop();
    chk("R5 empty after pop", rx_valid, 0);
  endtask

  task automatic t_nine();
    nine_bit_en = 1;
    send(9'h13C, 9, 0);
    send(9'h0C3, 9, 0);
    chk("R4 data low", rx_data, 8'h3C);
    chk("R4 ninth set", rx_status[0], 1);
    pop();
    chk("R4 second data", rx_data, 8'hC3);
    chk("R4 ninth clear", rx_status[0], 0);
    pop();
    chk("R4 empty ninth", rx_status[0], 0);
    nine_bit_en = 0;
  endtask

  task automatic t_order();
    send(9'h011, 8, 0);
    send(9'h022, 8, 0);
    repeat (5) @(negedge clk);
    chk("R5 stall valid", rx_valid, 1);
    chk("R5 first", rx_data, 8'h11);
    pop();
    chk("R5 second", rx_data, 8'h22);
    pop();
    chk("R5 drained", rx_valid, 0);
  endtask

  task automatic t_overrun();
    send(9'h033, 8, 0);
    send(9'h044, 8, 0);
    chk("R7 no overrun yet", rx_status[1], 0);
    send(9'h055, 8, 0);
    chk("R7 overrun set", rx_status[1], 1);
    chk("R7 kept first", rx_data, 8'h33);
    pop();
    chk("R7 kept second", rx_data, 8'h44);
    pop();
    chk("R7 third lost", rx_valid, 0);
    send(9'h066, 8, 0);
    chk("R7 inhibited", rx_valid, 0);
    port_en = 0;
    @(negedge clk);
    port_en = 1;
    @(negedge clk);
    chk("R8 port_en keeps overrun", rx_status[1], 1);
    cont_rx_en = 0;
    @(negedge clk);
    cont_rx_en = 1;
    @(negedge clk);
    chk("R8 cleared", rx_status[1], 0);
    send(9'h077, 8, 0);
    chk("R8 resumes", rx_data, 8'h77);
    pop();
  endtask

  task automatic t_gating();
    cont_rx_en = 0;
    send(9'h0AA, 8, 0);
    chk("R1 cont off", rx_valid, 0);
    cont_rx_en = 1; port_en = 0;
    send(9'h0AA, 8, 0);
    chk("R1 port off", rx_valid, 0);
    port_en = 1; sync_mode = 0;
    send(9'h0AA, 8, 0);
    chk("R1 async", rx_valid, 0);
    sync_mode = 1; clk_src_master = 1;
    send(9'h0AA, 8, 0);
    chk("R1 master src", rx_valid, 0);
    clk_src_master = 0;
    @(negedge clk);
  endtask

  task automatic t_single();
    single_rx_en = 1;
    send(9'h096, 8, 0);
    chk("R2 recv with single on", rx_data, 8'h96);
    chk("R11 single bit", rx_status[5], 1);
    pop();
    single_rx_en = 0;
    send(9'h069, 8, 0);
    chk("R2 recv with single off", rx_data, 8'h69);
    pop();
  endtask

  task automatic t_abandon();
    send(9'h0FF, 4, 0);
    cont_rx_en = 0;
    @(negedge clk);
    cont_rx_en = 1;
    send(9'h05A, 8, 0);
    chk("R9 cont abandon", rx_data, 8'h5A);
    pop();
    send(9'h0FF, 3, 0);
    port_en = 0;
    @(negedge clk);
    port_en = 1;
    send(9'h0C6, 8, 0);
    chk("R9 port abandon", rx_data, 8'hC6);
    pop();
    chk("R9 nothing extra", rx_valid, 0);
  endtask

  task automatic t_irq_wake();
    rx_int_en = 1; low_power = 1;
    @(negedge clk);
    chk("R6 irq idle", rx_irq, 0);
    chk("R10 wake idle", wake_req, 0);
    send(9'h081, 8, 0);
    chk("R10 rx in low power", rx_data, 8'h81);
    chk("R6 irq", rx_irq, 1);
    chk("R10 wake", wake_req, 1);
    rx_int_en = 0;
    @(negedge clk);
    chk("R6 irq masked", rx_irq, 0);
    chk("R10 wake masked", wake_req, 0);
    pop();
    low_power = 0;
  endtask

  task automatic t_status();
    nine_bit_en = 1; single_rx_en = 1;
    @(negedge clk);
    chk("R11 layout", rx_status, 8'hD0 | 8'h20);
    nine_bit_en = 0; single_rx_en = 0;
    @(negedge clk);
    chk("R11 layout base", rx_status, 8'h90);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_order();
    t_overrun();
    t_gating();
    t_single();
    t_abandon();
    t_irq_wake();
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule